// File: doc/BRIEF.md
# Tower-field byte inverter with mixed bases

This block returns the multiplicative inverse of one byte treated as an element of GF(2^8), where GF(2^8) is built as a tower of degree-two extensions: GF(2) to GF(4), GF(4) to GF(16), GF(16) to GF(256). It is the non-linear core of a substitution box. The caller maps bytes into this tower and applies the affine steps outside the block. The whole datapath is combinational.

The input is a pair of GF(16) coefficients in the conjugate, or normal, basis {γ, γ^16}. The output is a pair in the power, or polynomial, basis {1, γ}. Inside, each GF(16) sub-operator reads one basis and writes another. This lets the datapath skip the conversion networks between stages. There are five such sub-operators:
- a merged "square, then scale by v" unit;
- a mixed multiplier for the cross product al·ah;
- a GF(16) inverter that reads the normal basis and writes the polynomial basis;
- two polynomial-basis multipliers that form the output halves.

The GF(16) norm v(al+ah)^2 + al·ah is inverted, and the result is multiplied by al and by (al+ah).

Top module: `gf256_mixed_inv`

## Requirements
- R1: The input byte encodes A = al·γ + ah·γ^16.
  - al is bits [3:0] and ah is bits [7:4].
  - γ is a root of x^2+x+v over GF(16), with v encoded 4'b0100.
  - Each nibble is a polynomial-basis GF(16) element: bits [1:0] hold the constant term and bits [3:2] the coefficient of β, where β is a root of x^2+x+λ over GF(4).
  - λ = α^2 is encoded 2'b10.
  - Each 2-bit GF(4) element has bit 0 as the coefficient of α and bit 1 as the coefficient of α^2, where α^2+α+1 = 0. The GF(4) unit is therefore 2'b11.
- R2: The output byte encodes B = bl + bh·γ. bl is bits [3:0] and bh is bits [7:4], with nibbles encoded as in R1.
- R3: An input of 8'h00 gives an output of 8'h00.
- R4: For every non-zero input, A·B in GF(256) equals the multiplicative identity, whose polynomial-basis encoding is 8'h03. The output is the unique byte with this property.
- R5: The field identity, input 8'h33 (al = ah = 1), yields 8'h03.
- R6: The 255 non-zero inputs map to 255 distinct non-zero outputs.
- R7: The output depends only on the present input. It follows an input change within the same time step, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Element to invert, conjugate basis over GF(16) (R1) |
| y_o | output | 8 | Inverse, polynomial basis over GF(16) (R2) |

## Verification
The embedded checks assume two-state, fully driven input bytes and look only at settled combinational values. Each check relates a zero or non-zero operand to a zero or non-zero result at one sub-operator.

The stimulus honours these assumptions:
- it changes the input only mid-phase;
- it samples after settling;
- it covers all 256 codes exhaustively, then adds seeded random bytes.

Expected results come from a log-table GF(4) model and a schoolbook tower multiplier. A brute-force search over all 256 candidates finds each inverse.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;
  localparam int unsigned SubW  = 2;
  localparam int unsigned NibW  = 2 * SubW;
  localparam int unsigned ByteW = 2 * NibW;
  localparam int unsigned NHalf = ByteW / NibW;

  typedef logic [SubW-1:0] gf4_t;
  typedef logic [NibW-1:0] gf16_t;

  // normal basis {a, a^2}: bit0 -> a, bit1 -> a^2
  function automatic gf4_t gf4_mul(gf4_t x, gf4_t y);
    logic t;
    t = (x[0] ^ x[1]) & (y[0] ^ y[1]);
    return {t ^ (x[1] & y[1]), t ^ (x[0] & y[0])};
  endfunction

  function automatic gf4_t gf4_sq(gf4_t x);
    return {x[0], x[1]};
  endfunction

  function automatic gf4_t gf4_mul_a(gf4_t x);
    return {x[0] ^ x[1], x[1]};
  endfunction

  // scale by lambda = a^2
  function automatic gf4_t gf4_mul_lam(gf4_t x);
    return {x[0], x[0] ^ x[1]};
  endfunction
endpackage

// File: rtl/gf16_sqv_pn.sv
module gf16_sqv_pn import gf_tower_pkg::*; (
  input  logic [NibW-1:0] a_i,
  output logic [NibW-1:0] z_o
);
  gf4_t sl2, sh2, lo, hi;

  always_comb begin
    sl2 = gf4_sq(a_i[SubW-1:0]);
    sh2 = gf4_sq(a_i[NibW-1:SubW]);
    lo  = sh2;
    hi  = gf4_mul_a(sl2) ^ gf4_mul_lam(sh2);
    z_o = {lo, lo ^ hi};  // normal: [1:0]->b, [3:2]->b^4
  end

  always_comb begin
    assert_sqv_zero_R3: assert ((a_i != '0) || (z_o == '0));
  end
endmodule

// File: rtl/gf16_mul_pn.sv
module gf16_mul_pn import gf_tower_pkg::*; (
  input  logic [NibW-1:0] a_i,
  input  logic [NibW-1:0] b_i,
  output logic [NibW-1:0] c_o
);
  gf4_t ll, hh_l, mm;

  always_comb begin
    ll   = gf4_mul(a_i[SubW-1:0], b_i[SubW-1:0]);
    hh_l = gf4_mul_lam(gf4_mul(a_i[NibW-1:SubW], b_i[NibW-1:SubW]));
    mm   = gf4_mul(a_i[SubW-1:0] ^ a_i[NibW-1:SubW],
                   b_i[SubW-1:0] ^ b_i[NibW-1:SubW]);
    c_o  = {ll ^ hh_l, hh_l ^ mm};
  end

  always_comb begin
    assert_mixmul_zero_R3: assert (((a_i != '0) && (b_i != '0)) || (c_o == '0));
  end
endmodule

// File: rtl/gf16_mul_pp.sv
module gf16_mul_pp import gf_tower_pkg::*; (
  input  logic [NibW-1:0] a_i,
  input  logic [NibW-1:0] b_i,
  output logic [NibW-1:0] c_o
);
  gf4_t ll, hh_l, mm;

  always_comb begin
    ll   = gf4_mul(a_i[SubW-1:0], b_i[SubW-1:0]);
    hh_l = gf4_mul_lam(gf4_mul(a_i[NibW-1:SubW], b_i[NibW-1:SubW]));
    mm   = gf4_mul(a_i[SubW-1:0] ^ a_i[NibW-1:SubW],
                   b_i[SubW-1:0] ^ b_i[NibW-1:SubW]);
    c_o  = {mm ^ ll, ll ^ hh_l};
  end

  always_comb begin
    assert_genmul_zero_R3: assert (((a_i != '0) && (b_i != '0)) || (c_o == '0));
  end
endmodule

// File: rtl/gf16_inv_np.sv
module gf16_inv_np import gf_tower_pkg::*; (
  input  logic [NibW-1:0] z_i,
  output logic [NibW-1:0] r_o
);
  gf4_t x, y, sxy, nrm, ninv;

  always_comb begin
    x    = z_i[SubW-1:0];
    y    = z_i[NibW-1:SubW];
    sxy  = x ^ y;
    nrm  = gf4_mul_lam(gf4_sq(sxy)) ^ gf4_mul(x, y);
    ninv = gf4_sq(nrm);  // x^-1 = x^2 in GF(4)
    r_o  = {gf4_mul(sxy, ninv), gf4_mul(x, ninv)};
  end

  always_comb begin
    assert_inv16_zero_R3: assert ((z_i != '0) || (r_o == '0));
    assert_inv16_nonzero_R6: assert ((z_i == '0) || (r_o != '0));
  end
endmodule

// File: rtl/gf256_mixed_inv.sv
module gf256_mixed_inv import gf_tower_pkg::*; (
  input  logic [ByteW-1:0] a_i,
  output logic [ByteW-1:0] y_o
);
  logic [NibW-1:0] al, ah, s_sum, sqv_n, prod_n, norm_n, ninv_p;
  logic [NibW-1:0] mul_op [NHalf];

  assign al    = a_i[NibW-1:0];
  assign ah    = a_i[ByteW-1:NibW];
  assign s_sum = al ^ ah;

  gf16_sqv_pn u_sqv (.a_i(s_sum), .z_o(sqv_n));
  gf16_mul_pn u_mix (.a_i(al), .b_i(ah), .c_o(prod_n));

  assign norm_n = sqv_n ^ prod_n;

  gf16_inv_np u_inv (.z_i(norm_n), .r_o(ninv_p));

  // bl = al*N^-1, bh = (al+ah)*N^-1
  assign mul_op[0] = al;
  assign mul_op[1] = s_sum;

  for (genvar g = 0; g < NHalf; g++) begin : g_half
    gf16_mul_pp u_mul (
      .a_i(mul_op[g]),
      .b_i(ninv_p),
      .c_o(y_o[g*NibW +: NibW])
    );
  end

  always_comb begin
    assert_zero_in_zero_out_R3: assert ((a_i != '0) || (y_o == '0));
    assert_nonzero_out_R6: assert ((a_i == '0) || (y_o != '0));
  end
endmodule

// File: tb/gf256_mixed_inv_bench.sv
module gf256_mixed_inv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic [7:0] a;
  logic [7:0] y;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;
  bit         seen [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  gf256_mixed_inv u_gf256_mixed_inv (.a_i(a), .y_o(y));

  // GF(4) via logs, generator alpha: 11->0, 01->1, 10->2
  function automatic int lg4(logic [1:0] x);
    case (x)
      2'b11:   return 0;
      2'b01:   return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [1:0] ex4(int e);
    case (e % 3)
      0:       return 2'b11;
      1:       return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [1:0] rm4(logic [1:0] x, logic [1:0] z);
    if (x == 2'b00 || z == 2'b00) return 2'b00;
    return ex4(lg4(x) + lg4(z));
  endfunction

  // GF(16) poly basis {1,b}, b^2 = b + lambda, lambda = 2'b10
  function automatic logic [3:0] rm16(logic [3:0] p, logic [3:0] q);
    logic [1:0] r0, r1;
    r0 = rm4(p[1:0], q[1:0]) ^ rm4(2'b10, rm4(p[3:2], q[3:2]));
    r1 = rm4(p[1:0], q[3:2]) ^ rm4(p[3:2], q[1:0]) ^ rm4(p[3:2], q[3:2]);
    return {r1, r0};
  endfunction

  // a in {g, g^16}, b in {1, g}; g^2 = g + v, v = 4'b0100; product in {1,g}
  function automatic logic [7:0] rmul(logic [7:0] an, logic [7:0] bp);
    logic [3:0] x0, x1, p0, p1;
    x0 = an[7:4];
    x1 = an[3:0] ^ an[7:4];
    p0 = rm16(x0, bp[3:0]) ^ rm16(4'b0100, rm16(x1, bp[7:4]));
    p1 = rm16(x0, bp[7:4]) ^ rm16(x1, bp[3:0]) ^ rm16(x1, bp[7:4]);
    return {p1, p0};
  endfunction

  function automatic logic [7:0] rinv(logic [7:0] an);
    for (int c = 1; c < 256; c++)
      if (rmul(an, c[7:0]) == 8'h03) return c[7:0];
    return 8'h00;
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s in=%02h actual=%02h expected=%02h", req, a, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] v);
    @(negedge clk);
    a = v;
    #1;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] e;
    a = 8'h00;
    r = 8'($urandom(32'd20240607));

    // R3: zero maps to zero
    drive(8'h00);
    chk(y == 8'h00, "R3", y, 8'h00);

    // R5: identity 1 = g + g^16 -> 8'h33, inverse 8'h03
    drive(8'h33);
    chk(y == 8'h03, "R5", y, 8'h03);

    // R7: follows input without any clock edge
    @(negedge clk);
    a = 8'h33; #1;
    chk(y == 8'h03, "R7", y, 8'h03);
    a = 8'h00; #1;
    chk(y == 8'h00, "R7", y, 8'h00);
    a = 8'h33; #1;
    chk(y == 8'h03, "R7", y, 8'h03);

    // R1, R2, R4: exhaustive over non-zero inputs
    for (int i = 1; i < 256; i++) begin
      drive(i[7:0]);
      chk(rmul(a, y) == 8'h03, "R4", rmul(a, y), 8'h03);
      e = rinv(a);
      chk(y == e, "R1/R2", y, e);
      chk(!seen[y] && y != 8'h00, "R6", y, e);
      seen[y] = 1'b1;
    end

    // R3 again after sweep
    drive(8'h00);
    chk(y == 8'h00, "R3", y, 8'h00);

    // seeded random bytes
    for (int k = 0; k < 200; k++) begin
      r = 8'($urandom);
      drive(r);
      if (r == 8'h00) chk(y == 8'h00, "R3", y, 8'h00);
      else            chk(rmul(a, y) == 8'h03, "R4", rmul(a, y), 8'h03);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule